// File: doc/BRIEF.md
# Register-Mapped UART with Byte Queues

This block is a serial port that sits on a simple 32-bit word bus. Software selects the bit rate by writing a clock-divider count. It pushes bytes into a 16-entry transmit queue, and they leave on a single line as frames of one start bit, eight data bits sent least significant bit first, and one stop bit. Incoming frames are sampled at mid-bit with the same divider, and the bytes are stored in a 16-entry receive queue. Software drains that queue by reading the data word.

The bus takes one request per cycle. Each request is answered one cycle later with a response-valid strobe, the read data and an error flag. Four word offsets are mapped: 0 is the interrupt word, 1 is the divider, 2 is the status word and 3 is the data word. Reading the divider word has a side effect: it empties both queues. Software uses this to restart the port. A level interrupt output stays high while received bytes are waiting.

Top module: `uart_regs`

## Requirements
- R1: Every request with `bus_en` high gets `bus_rvalid` high on the next cycle. `bus_err` is set for any offset of 4 or above and for a write to offset 2. Writes return read data 0.
- R2: Writing offset 1 loads the divider from the low 16 bits. Reading offset 1 returns the divider. The divider resets to 868.
- R3: A read of offset 1 empties both the transmit queue and the receive queue in the same cycle.
- R4: In the status word at offset 2, bit 0 is 1 while the receive queue is not empty, and bit 1 is 1 while the transmit queue holds 16 bytes. All other bits are 0.
- R5: A read of offset 3 with bytes waiting pops the oldest byte and returns it in bits 7:0 with bit 8 set. A read with the queue empty returns 0 and pops nothing.
- R6: A write to offset 3 queues bits 7:0 of the write data. A write while the transmit queue is full is dropped, and the queued bytes stay unchanged.
- R7: Reading offset 0 returns 3 while received bytes are waiting and 0 otherwise. `irq` shows the same condition. A write to offset 0 is accepted without error.
- R8: Each queued byte leaves `uart_tx` as a low start bit, eight data bits least significant bit first, and a high stop bit. Each bit lasts one divider count of cycles. The line is high while no frame is being sent.
- R9: The receiver detects a falling edge on `uart_rx` and confirms the start bit at half a bit period. It then samples each bit at its centre. A byte is queued only if its stop bit is 1.
- R10: After reset, `bus_rvalid` and `irq` are low, `uart_tx` is high, and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response strobe, one cycle after the request |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Invalid access |
| irq | output | 1 | Received bytes waiting |
| uart_tx | output | 1 | Serial output |
| uart_rx | input | 1 | Serial input |

## Verification
The bench writes 18 bytes back to back. Because the first byte moves straight into the shifter, the queue fills at the seventeenth write and the eighteenth must vanish. A design that overwrote the oldest entry, or let the count wrap, would return a wrong or extra byte on loopback. A frame whose stop bit is 0 must leave the receive queue empty, and a design that skipped the stop check would report data waiting. Reading the divider while both queues hold data must clear both, and reading the data word with the queue empty must return exactly zero rather than a stale byte. The transmit line is decoded independently at bit centres, so a design with the wrong bit order or bit length produces a different byte.

// File: rtl/uart_regs.sv
module uart_regs #(
  parameter int ADDR_W    = 4,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 868,
  parameter int DEPTH     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              irq,
  output logic              uart_tx,
  input  logic              uart_rx
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DIV_W-1:0] div;
  logic [7:0]    txq [DEPTH];
  logic [7:0]    rxq [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire       mapped = (bus_addr[ADDR_W-1:2] == '0);
  wire [1:0] sel    = bus_addr[1:0];
  wire       rd     = bus_en & ~bus_we & mapped;
  wire       wr     = bus_en & bus_we & mapped;
  wire       flush  = rd & (sel == 2'd1);
  wire       tx_full  = (tx_cnt == CW'(DEPTH));
  wire       rx_avail = (rx_cnt != '0);
  wire       tx_push = wr & (sel == 2'd3) & ~tx_full;
  wire       rx_pop  = rd & (sel == 2'd3) & rx_avail;

  assign irq = rx_avail;

  // transmit shifter
  logic             tx_busy;
  logic [9:0]       tx_sh;
  logic [3:0]       tx_bit;
  logic [DIV_W-1:0] tx_tmr;
  wire tx_pop  = ~tx_busy & (tx_cnt != '0) & ~flush;
  wire tx_tick = (tx_tmr >= div - DIV_W'(1));
  assign uart_tx = tx_busy ? tx_sh[0] : 1'b1;

  // receive sampler
  logic [2:0]       rx_s;
  logic             rx_busy;
  logic [3:0]       rx_bit;
  logic [7:0]       rx_sh;
  logic [DIV_W-1:0] rx_tmr;
  wire             rx_in   = rx_s[1];
  wire [DIV_W-1:0] rx_lim  = (rx_bit == 4'd0) ? (div >> 1) : div;
  wire             rx_tick = rx_busy & (rx_tmr >= rx_lim - DIV_W'(1));
  wire             rx_push = rx_tick & (rx_bit == 4'd9) & rx_in & (rx_cnt != CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (tx_push) txq[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rxq[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_bit <= '0; tx_tmr <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1; tx_sh <= {1'b1, txq[tx_rp], 1'b0};
      tx_bit <= '0; tx_tmr <= '0;
    end else if (tx_busy) begin
      if (tx_tick) begin
        tx_tmr <= '0;
        tx_sh  <= {1'b1, tx_sh[9:1]};
        tx_bit <= tx_bit + 1'b1;
        if (tx_bit == 4'd9) tx_busy <= 1'b0;
      end else begin
        tx_tmr <= tx_tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s <= '1; rx_busy <= 1'b0; rx_bit <= '0; rx_sh <= '0; rx_tmr <= '0;
    end else begin
      rx_s <= {rx_s[1:0], uart_rx};
      if (!rx_busy) begin
        if (rx_s[2] & ~rx_in) begin
          rx_busy <= 1'b1; rx_bit <= '0; rx_tmr <= '0;
        end
      end else if (rx_tick) begin
        rx_tmr <= '0;
        rx_bit <= rx_bit + 1'b1;
        if (rx_bit == 4'd0 && rx_in) rx_busy <= 1'b0;
        else if (rx_bit == 4'd9)     rx_busy <= 1'b0;
        else                         rx_sh <= {rx_in, rx_sh[7:1]};
      end else begin
        rx_tmr <= rx_tmr + 1'b1;
      end
    end
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (rd) begin
      case (sel)
        2'd0: rd_next = rx_avail ? 32'd3 : 32'd0;
        2'd1: rd_next = 32'(div);
        2'd2: rd_next = {30'd0, tx_full, rx_avail};
        default: rd_next = rx_avail ? {23'd0, 1'b1, rxq[rx_rp]} : 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= DIV_W'(DIV_RESET);
      bus_rvalid <= 1'b0; bus_rdata <= '0; bus_err <= 1'b0;
    end else begin
      bus_rvalid <= bus_en;
      bus_rdata  <= rd_next;
      bus_err    <= bus_en & (~mapped | (bus_we & (sel == 2'd2)));
      if (wr && sel == 2'd1) div <= bus_wdata[DIV_W-1:0];
    end
  end
endmodule

module uart_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int CW     = 5,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              irq,
  input logic              uart_tx,
  input logic              tx_busy,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt
);
  p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> bus_rvalid);
  p_unmapped_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr >= ADDR_W'(4)) |=> bus_err);
  p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(1)) |=> (tx_cnt == '0 && rx_cnt == '0));
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(3) && rx_cnt == '0) |=> bus_rdata == 32'd0);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));
  p_irq_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(0)) |=> bus_rdata == ($past(irq) ? 32'd3 : 32'd0));
  p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !uart_tx);
endmodule

bind uart_regs uart_regs_chk #(.ADDR_W(ADDR_W), .CW(CW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq),
  .uart_tx(uart_tx), .tx_busy(tx_busy), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/uart_regs_tb.sv
module uart_regs_tb_top;
  localparam int PERIOD = 10;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid, bus_err, irq, tx_line, rx_line;
  logic [31:0] bus_rdata;
  logic rx_drv = 1'b1, loop = 1'b0;
  int checks = 0, fails = 0;

  assign rx_line = loop ? tx_line : rx_drv;
  always #(PERIOD/2) clk = ~clk;

  uart_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq), .uart_tx(tx_line), .uart_rx(rx_line)
  );

  typedef struct packed {
    logic we; logic [3:0] addr; logic [31:0] wd; logic err; logic [31:0] rd;
  } vec_t;
  localparam vec_t VEC [10] = '{
    '{1'b1, 4'd1, 32'd8,   1'b0, 32'd0},  // R2 divider write
    '{1'b0, 4'd1, 32'd0,   1'b0, 32'd8},  // R2 readback
    '{1'b0, 4'd2, 32'd0,   1'b0, 32'd0},  // R4 idle status
    '{1'b0, 4'd0, 32'd0,   1'b0, 32'd0},  // R7 no pending
    '{1'b0, 4'd3, 32'd0,   1'b0, 32'd0},  // R5 empty read
    '{1'b1, 4'd2, 32'd5,   1'b1, 32'd0},  // R1 status write invalid
    '{1'b0, 4'd5, 32'd0,   1'b1, 32'd0},  // R1 unmapped read
    '{1'b1, 4'd9, 32'd1,   1'b1, 32'd0},  // R1 unmapped write
    '{1'b1, 4'd0, 32'd1,   1'b0, 32'd0},  // R7 ack write
    '{1'b0, 4'd15, 32'd0,  1'b1, 32'd0}   // R1 top offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [3:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    rd = bus_rdata; er = bus_err;
    if (!bus_rvalid) begin
      checks++; fails++;
      $display("FAIL R1 actual rvalid=0 expected=1");
    end
    bus_en = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    rx_drv = 1'b0; repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_drv = b[i]; repeat (DIV) @(negedge clk); end
    rx_drv = stop; repeat (DIV) @(negedge clk);
    rx_drv = 1'b1; repeat (DIV) @(negedge clk);
  endtask

  task automatic grab_tx(output logic [7:0] b, output logic ok);
    int n = 0;
    ok = 1'b1;
    while (tx_line && n < 1000) begin @(negedge clk); n++; end
    repeat (DIV/2) @(negedge clk);
    if (tx_line) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin repeat (DIV) @(negedge clk); b[i] = tx_line; end
    repeat (DIV) @(negedge clk);
    if (!tx_line) ok = 1'b0;
  endtask

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic er; logic [7:0] b; logic ok;
    repeat (3) @(negedge clk);
    check("R10 rvalid", {31'd0, bus_rvalid}, 32'd0);
    check("R10 tx idle", {31'd0, tx_line}, 32'd1);
    check("R10 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    bus(1'b0, 4'd2, 0, rd, er); check("R10 status", rd, 32'd0);
    bus(1'b0, 4'd1, 0, rd, er); check("R2 default divider", rd, 32'd868);

    for (int i = 0; i < 10; i++) begin
      bus(VEC[i].we, VEC[i].addr, VEC[i].wd, rd, er);
      check("R1 err vector", {31'd0, er}, {31'd0, VEC[i].err});
      check("R1/R2/R4/R5/R7 data vector", rd, VEC[i].rd);
    end

    // R8 and R6: bits 7:0 only, LSB first
    bus(1'b1, 4'd3, 32'h1A5, rd, er);
    grab_tx(b, ok);
    check("R8 frame bits", {24'd0, b}, 32'hA5);
    check("R8 start/stop", {31'd0, ok}, 32'd1);

    // R9 good frame, R5/R7/R4
    send_rx(8'h3C, 1'b1);
    check("R7 irq pin", {31'd0, irq}, 32'd1);
    bus(1'b0, 4'd2, 0, rd, er); check("R4 rx ready", rd, 32'd1);
    bus(1'b0, 4'd0, 0, rd, er); check("R7 pending", rd, 32'd3);
    bus(1'b0, 4'd3, 0, rd, er); check("R9 R5 pop", rd, 32'h13C);
    bus(1'b0, 4'd3, 0, rd, er); check("R5 empty", rd, 32'd0);
    bus(1'b0, 4'd0, 0, rd, er); check("R7 cleared", rd, 32'd0);

    // R9 framing error
    send_rx(8'h55, 1'b0);
    repeat (DIV) @(negedge clk);
    bus(1'b0, 4'd2, 0, rd, er); check("R9 bad stop dropped", rd, 32'd0);

    // R3 flush
    send_rx(8'h11, 1'b1);
    for (int i = 0; i < 18; i++) bus(1'b1, 4'd3, i, rd, er);
    bus(1'b0, 4'd2, 0, rd, er); check("R4 full and ready", rd, 32'd3);
    bus(1'b0, 4'd1, 0, rd, er); check("R3 divider read", rd, 32'd8);
    bus(1'b0, 4'd2, 0, rd, er); check("R3 queues emptied", rd, 32'd0);
    bus(1'b0, 4'd3, 0, rd, er); check("R3 rx empty", rd, 32'd0);
    repeat (200) @(negedge clk);

    // R6 overflow drop, checked through loopback
    loop = 1'b1;
    for (int i = 0; i < 18; i++) bus(1'b1, 4'd3, 32'h100 + i, rd, er);
    bus(1'b0, 4'd2, 0, rd, er); check("R4 tx full", rd, 32'd2);
    repeat (680) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      bus(1'b0, 4'd3, 0, rd, er); check("R6 loop byte", rd, 32'h100 + i);
    end
    repeat (800) @(negedge clk);
    for (int i = 8; i < 17; i++) begin
      bus(1'b0, 4'd3, 0, rd, er); check("R6 loop byte", rd, 32'h100 + i);
    end
    bus(1'b0, 4'd3, 0, rd, er); check("R6 dropped byte absent", rd, 32'd0);
    check("R8 idle after", {31'd0, tx_line}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule